// File: doc/BRIEF.md
# UART with Sleep, Idle and Wake Handling

This block is an 8N1 serial transmitter and receiver, each with a one-entry buffer. It follows the system's power states. A sleep request stops the module's internal clock enable. It also abandons any frame in flight and parks the transmit line high. Buffers and configuration inputs are left untouched. An idle request stops the block only when the stop-in-idle select is set. Otherwise the block keeps working through idle.

While asleep, a falling edge on the receive line can raise the receive interrupt. This needs both the module enable and the wake enable. The edge is caught by a latch that is set directly by the line, so no baud timing is involved. The latch is then brought into the system clock domain through two flops. The interrupt select that filters normal receive interrupts has no say over this wake event.

For automatic baud detection, the block times each low interval on the receive line in system clocks. The first such interval of a character is its start bit. The measured count is presented with a one-cycle strobe and saturates at its maximum value.

Top module: `uart_lp_ctrl`

## Requirements
- R1: A byte accepted through `tx_valid` while `tx_ready` is high is sent on `txd` as one low start bit, then eight data bits least significant bit first, then one high stop bit. Each bit lasts `baud_div` clocks, and the line is high when no frame is being sent. `tx_ready` falls in the cycle after the byte is accepted.
- R2: Each received frame is stored in `rx_data` and sets `rx_full`. A `rx_read` pulse clears `rx_full`.
- R3: With `rx_ie` high, `rx_irq` gives one pulse per completed frame. When `rxi_sel` is 0, every frame pulses. When `rxi_sel` is 1, only frames whose stop bit is 1 pulse. The byte is stored in either case.
- R4: Asserting `sleep_req` abandons a frame being sent. `txd` is 1 from the cycle after sleep begins until sleep ends, and the abandoned frame is not resumed afterwards.
- R5: Asserting `sleep_req` abandons a frame being received. No byte from it is stored. After sleep the receiver needs a fresh falling edge before it will take a new frame.
- R6: Sleep leaves `rx_data`, `rx_full` and a byte waiting in the transmit buffer unchanged. A byte written to the buffer during sleep is held, and sent once sleep ends.
- R7: `clk_en` is 0 whenever `sleep_req` is high, `mod_en` is low, or `idle_req` and `stop_in_idle` are both high. Otherwise it is 1.
- R8: With `stop_in_idle` = 0, transfers run normally during idle. With `stop_in_idle` = 1, idle freezes the block, and a byte loaded during idle goes out intact after idle ends.
- R9: A falling edge on `rxd` during sleep gives one `rx_irq` pulse within a few clocks, whatever `rxi_sel` is set to. This happens only when `wake_en`, `mod_en` and `rx_ie` are all high.
- R10: With `abd_en` high, each low interval of W system clocks on `rxd` is reported as `abd_count` = W with a one-cycle `abd_valid` strobe. The count stops at 2^CNT_W − 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_req | input | 1 | System sleep state |
| idle_req | input | 1 | System idle state |
| mod_en | input | 1 | Module enable |
| wake_en | input | 1 | Allow a receive-line falling edge to wake from sleep |
| stop_in_idle | input | 1 | 1: halt during idle; 0: keep running |
| rxi_sel | input | 1 | Receive interrupt select: 0 every frame, 1 only good-stop frames |
| rx_ie | input | 1 | Receive interrupt enable |
| abd_en | input | 1 | Enable low-interval timing on the receive line |
| baud_div | input | DIV_W | System clocks per bit |
| tx_data | input | 8 | Byte to send |
| tx_valid | input | 1 | Write `tx_data` into the transmit buffer |
| tx_ready | output | 1 | Transmit buffer empty |
| txd | output | 1 | Serial output |
| rxd | input | 1 | Serial input |
| rx_data | output | 8 | Last received byte |
| rx_full | output | 1 | Receive buffer holds an unread byte |
| rx_read | input | 1 | Clear `rx_full` |
| rx_irq | output | 1 | Receive or wake interrupt pulse |
| abd_count | output | CNT_W | Measured low-interval width in clocks |
| abd_valid | output | 1 | Strobe for `abd_count` |
| clk_en | output | 1 | Internal module clock enable |

## Verification
The bench drops into sleep partway through an all-zero transmit frame. A design that only gates the clock would leave `txd` low, or finish the old frame once sleep ends. It also sleeps partway through a receive frame. A receiver that resumed the partial frame would store a bogus byte or lose framing on the next character. It writes to the transmit buffer during sleep and expects that byte, and an unread received byte, to survive. A design that resets on sleep entry would lose both. The wake test turns each of wake enable, module enable and interrupt enable off in turn, and runs with `rxi_sel` set so that a wrongly filtered wake would go silent. The baud timer is driven past its 8-bit limit in the bench build, so a counter that wraps instead of saturating would report a small value.

// File: rtl/uart_lp_ctrl.sv
module uart_lp_ctrl #(
  parameter int DIV_W = 16,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sleep_req,
  input  logic             idle_req,
  input  logic             mod_en,
  input  logic             wake_en,
  input  logic             stop_in_idle,
  input  logic             rxi_sel,
  input  logic             rx_ie,
  input  logic             abd_en,
  input  logic [DIV_W-1:0] baud_div,
  input  logic [7:0]       tx_data,
  input  logic             tx_valid,
  output logic             tx_ready,
  output logic             txd,
  input  logic             rxd,
  output logic [7:0]       rx_data,
  output logic             rx_full,
  input  logic             rx_read,
  output logic             rx_irq,
  output logic [CNT_W-1:0] abd_count,
  output logic             abd_valid,
  output logic             clk_en
);

  assign clk_en = mod_en & ~sleep_req & ~(idle_req & stop_in_idle);

  // transmitter
  logic [7:0]       tx_buf;
  logic             tx_bfull;
  logic [8:0]       tx_sh;
  logic [3:0]       tx_bits;
  logic [DIV_W-1:0] tx_cnt;
  logic             tx_line;

  assign tx_ready = ~tx_bfull;
  assign txd      = tx_line;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_buf <= '0; tx_bfull <= 1'b0; tx_sh <= '0;
      tx_bits <= '0; tx_cnt <= '0; tx_line <= 1'b1;
    end else begin
      if (tx_valid && !tx_bfull) begin
        tx_buf   <= tx_data;
        tx_bfull <= 1'b1;
      end
      if (sleep_req) begin
        tx_bits <= '0;
        tx_line <= 1'b1;
      end else if (clk_en) begin
        if (tx_bits == 4'd0) begin
          if (tx_bfull) begin
            tx_sh    <= {1'b1, tx_buf};
            tx_bits  <= 4'd10;
            tx_cnt   <= baud_div - DIV_W'(1);
            tx_line  <= 1'b0;
            tx_bfull <= 1'b0;
          end
        end else if (tx_cnt == '0) begin
          tx_bits <= tx_bits - 4'd1;
          tx_cnt  <= baud_div - DIV_W'(1);
          if (tx_bits == 4'd1) tx_line <= 1'b1;
          else begin
            tx_line <= tx_sh[0];
            tx_sh   <= {1'b0, tx_sh[8:1]};
          end
        end else begin
          tx_cnt <= tx_cnt - DIV_W'(1);
        end
      end
    end
  end

  // receive line synchronizer
  logic rx_m, rx_s, rx_p;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) {rx_m, rx_s, rx_p} <= 3'b111;
    else        {rx_m, rx_s, rx_p} <= {rxd, rx_m, rx_s};
  end
  wire rx_fall = rx_p & ~rx_s;
  wire rx_rise = ~rx_p & rx_s;

  // receiver
  logic [3:0]       rx_bits;
  logic [DIV_W-1:0] rx_cnt;
  logic [7:0]       rx_sh;
  wire rx_done = clk_en & (rx_bits == 4'd1) & (rx_cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_bits <= '0; rx_cnt <= '0; rx_sh <= '0;
      rx_data <= '0; rx_full <= 1'b0;
    end else begin
      if (rx_read) rx_full <= 1'b0;
      if (sleep_req) begin
        rx_bits <= '0;
      end else if (clk_en) begin
        if (rx_bits == 4'd0) begin
          if (rx_fall) begin
            rx_bits <= 4'd10;
            rx_cnt  <= baud_div >> 1;
          end
        end else if (rx_cnt == '0) begin
          rx_cnt  <= baud_div - DIV_W'(1);
          rx_bits <= rx_bits - 4'd1;
          if (rx_bits == 4'd10) begin
            if (rx_s) rx_bits <= '0;
          end else if (rx_bits == 4'd1) begin
            rx_data <= rx_sh;
            rx_full <= 1'b1;
          end else begin
            rx_sh <= {rx_s, rx_sh[7:1]};
          end
        end else begin
          rx_cnt <= rx_cnt - DIV_W'(1);
        end
      end
    end
  end

  // wake: latch set straight from the line, then two flops on clk
  wire  wake_arm = sleep_req & wake_en & mod_en;
  logic wake_lat, wake_clr, wk_m, wk_s, wk_d;

  always_ff @(negedge rxd or negedge rst_n or posedge wake_clr) begin
    if (!rst_n)        wake_lat <= 1'b0;
    else if (wake_clr) wake_lat <= 1'b0;
    else if (wake_arm) wake_lat <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) {wk_m, wk_s, wk_d, wake_clr} <= '0;
    else begin
      wk_m     <= wake_lat;
      wk_s     <= wk_m;
      wk_d     <= wk_s;
      wake_clr <= wk_s;
    end
  end
  wire wake_pulse = wk_s & ~wk_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rx_irq <= 1'b0;
    else rx_irq <= rx_ie & ((rx_done & (~rxi_sel | rx_s)) | wake_pulse);
  end

  // start-bit width capture
  logic             abd_on;
  logic [CNT_W-1:0] abd_acc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      abd_on <= 1'b0; abd_acc <= '0; abd_count <= '0; abd_valid <= 1'b0;
    end else begin
      abd_valid <= 1'b0;
      if (!abd_en || !clk_en) begin
        abd_on <= 1'b0;
      end else if (rx_fall) begin
        abd_on  <= 1'b1;
        abd_acc <= CNT_W'(1);
      end else if (abd_on) begin
        if (rx_rise) begin
          abd_count <= abd_acc;
          abd_valid <= 1'b1;
          abd_on    <= 1'b0;
        end else if (abd_acc != '1) begin
          abd_acc <= abd_acc + CNT_W'(1);
        end
      end
    end
  end

endmodule

module uart_lp_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic sleep_req,
  input logic idle_req,
  input logic stop_in_idle,
  input logic tx_valid,
  input logic tx_ready,
  input logic txd,
  input logic rx_ie,
  input logic rx_irq,
  input logic abd_valid,
  input logic clk_en
);
  // R1
  tx_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && tx_ready |=> !tx_ready);
  // R4
  tx_park_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_req && $past(sleep_req) |-> txd);
  // R7
  sleep_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_req |-> !clk_en);
  // R8
  idle_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idle_req && stop_in_idle |-> !clk_en);
  // R9
  irq_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq |-> $past(rx_ie));
  // R10
  abd_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abd_valid |=> !abd_valid);
endmodule

bind uart_lp_ctrl uart_lp_ctrl_chk chk_i (.*);

// File: tb/uart_lp_ctrl_tb.sv
module uart_lp_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int BD = 16;
  localparam int CW = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sleep_req = 0, idle_req = 0, mod_en = 1, wake_en = 0, stop_in_idle = 0;
  logic rxi_sel = 0, rx_ie = 1, abd_en = 0, tx_valid = 0, rxd = 1, rx_read = 0;
  logic [15:0] baud_div = BD;
  logic [7:0] tx_data = 0;
  logic tx_ready, txd, rx_full, rx_irq, abd_valid, clk_en;
  logic [7:0] rx_data;
  logic [CW-1:0] abd_count;

  int checks = 0, errors = 0, irq_cnt = 0, abd_cnt = 0;

  uart_lp_ctrl #(.DIV_W(16), .CNT_W(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .idle_req(idle_req),
    .mod_en(mod_en), .wake_en(wake_en), .stop_in_idle(stop_in_idle),
    .rxi_sel(rxi_sel), .rx_ie(rx_ie), .abd_en(abd_en), .baud_div(baud_div),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready), .txd(txd),
    .rxd(rxd), .rx_data(rx_data), .rx_full(rx_full), .rx_read(rx_read),
    .rx_irq(rx_irq), .abd_count(abd_count), .abd_valid(abd_valid), .clk_en(clk_en));

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) begin
    if (rx_irq) irq_cnt++;
    if (abd_valid) abd_cnt++;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic load_tx(input logic [7:0] d);
    @(negedge clk); tx_data = d; tx_valid = 1;
    @(negedge clk); tx_valid = 0;
  endtask

  task automatic grab_tx(output logic [7:0] d, output logic stop);
    int guard = 0;
    while (txd !== 1'b0 && guard < 40*BD) begin @(negedge clk); guard++; end
    clks(BD/2);
    for (int i = 0; i < 8; i++) begin clks(BD); d[i] = txd; end
    clks(BD); stop = txd;
  endtask

  task automatic send_rx(input logic [7:0] d, input logic stop);
    @(negedge clk); rxd = 0; clks(BD);
    for (int i = 0; i < 8; i++) begin rxd = d[i]; clks(BD); end
    rxd = stop; clks(BD);
    rxd = 1; clks(2*BD);
  endtask

  task automatic t_reset;
    chk("R1 txd idle", txd, 1);
    chk("R1 tx_ready", tx_ready, 1);
    chk("R2 rx_full", rx_full, 0);
    chk("R3 rx_irq", rx_irq, 0);
    chk("R10 abd_valid", abd_valid, 0);
    chk("R7 clk_en", clk_en, 1);
  endtask

  task automatic t_tx;
    logic [7:0] d; logic s;
    load_tx(8'hA5); grab_tx(d, s);
    chk("R1 byte A5", d, 8'hA5); chk("R1 stop", s, 1);
    load_tx(8'h3C); grab_tx(d, s);
    chk("R1 byte 3C", d, 8'h3C); chk("R1 stop", s, 1);
    clks(2*BD);
  endtask

  task automatic t_rx;
    int base;
    rxi_sel = 0; base = irq_cnt;
    send_rx(8'h5A, 1);
    chk("R2 data", rx_data, 8'h5A); chk("R2 full", rx_full, 1);
    chk("R3 irq sel0", irq_cnt - base, 1);
    @(negedge clk); rx_read = 1; @(negedge clk); rx_read = 0;
    chk("R2 read clears", rx_full, 0);
    rxi_sel = 1; base = irq_cnt;
    send_rx(8'hC7, 0);
    chk("R3 sel1 bad stop irq", irq_cnt - base, 0);
    chk("R3 sel1 bad stop data", rx_data, 8'hC7);
    base = irq_cnt;
    send_rx(8'h1E, 1);
    chk("R3 sel1 good stop irq", irq_cnt - base, 1);
    rxi_sel = 0;
    @(negedge clk); rx_read = 1; @(negedge clk); rx_read = 0;
  endtask

  task automatic t_sleep_tx;
    int bad = 0;
    load_tx(8'h00);
    clks(4*BD);
    sleep_req = 1; @(negedge clk);
    chk("R7 clk_en in sleep", clk_en, 0);
    for (int i = 0; i < 3*BD; i++) begin @(negedge clk); if (txd !== 1'b1) bad++; end
    sleep_req = 0;
    for (int i = 0; i < 12*BD; i++) begin @(negedge clk); if (txd !== 1'b1) bad++; end
    chk("R4 txd high and no resume", bad, 0);
  endtask

  task automatic t_sleep_rx;
    @(negedge clk); rxd = 0; clks(4*BD);
    sleep_req = 1; clks(2*BD); rxd = 1; clks(BD);
    sleep_req = 0; clks(12*BD);
    chk("R5 aborted frame not stored", rx_full, 0);
    send_rx(8'h81, 1);
    chk("R5 fresh frame", rx_data, 8'h81);
    chk("R5 fresh frame full", rx_full, 1);
    @(negedge clk); rx_read = 1; @(negedge clk); rx_read = 0;
  endtask

  task automatic t_retain;
    logic [7:0] d; logic s; int bad = 0;
    send_rx(8'h42, 1);
    sleep_req = 1; clks(2);
    load_tx(8'h99);
    for (int i = 0; i < 4*BD; i++) begin @(negedge clk); if (txd !== 1'b1) bad++; end
    chk("R6 no send in sleep", bad, 0);
    chk("R6 tx buffer held", tx_ready, 0);
    sleep_req = 0;
    grab_tx(d, s);
    chk("R6 held byte sent", d, 8'h99);
    chk("R6 rx_data kept", rx_data, 8'h42);
    chk("R6 rx_full kept", rx_full, 1);
    @(negedge clk); rx_read = 1; @(negedge clk); rx_read = 0;
    clks(2*BD);
  endtask

  task automatic t_idle;
    logic [7:0] d; logic s; int bad = 0;
    idle_req = 1; stop_in_idle = 0;
    chk("R7 clk_en idle run", clk_en, 1);
    load_tx(8'h6B); grab_tx(d, s);
    chk("R8 idle run byte", d, 8'h6B);
    clks(2*BD);
    stop_in_idle = 1; @(negedge clk);
    chk("R7 clk_en idle stop", clk_en, 0);
    load_tx(8'hC3);
    for (int i = 0; i < 5*BD; i++) begin @(negedge clk); if (txd !== 1'b1) bad++; end
    chk("R8 frozen in idle", bad, 0);
    idle_req = 0; grab_tx(d, s);
    chk("R8 byte after idle", d, 8'hC3);
    stop_in_idle = 0;
    mod_en = 0; @(negedge clk);
    chk("R7 clk_en mod off", clk_en, 0);
    mod_en = 1; clks(2*BD);
  endtask

  task automatic wake_try(input logic we, input logic me, input logic ie, input int exp, input string tag);
    int base;
    wake_en = we; mod_en = me; rx_ie = ie; rxi_sel = 1;
    sleep_req = 1; clks(4); base = irq_cnt;
    rxd = 0; clks(3); rxd = 1; clks(12);
    chk(tag, irq_cnt - base, exp);
    sleep_req = 0; clks(4);
    wake_en = 0; mod_en = 1; rx_ie = 1; rxi_sel = 0;
  endtask

  task automatic t_wake;
    wake_try(1, 1, 1, 1, "R9 wake irq");
    wake_try(0, 1, 1, 0, "R9 no wake_en");
    wake_try(1, 0, 1, 0, "R9 no mod_en");
    wake_try(1, 1, 0, 0, "R9 no rx_ie");
  endtask

  task automatic t_abd;
    int base;
    abd_en = 1; rx_ie = 0; base = abd_cnt;
    @(negedge clk); rxd = 0; clks(37); rxd = 1; clks(12*BD);
    chk("R10 width 37", abd_count, 37);
    chk("R10 one strobe", abd_cnt - base, 1);
    @(negedge clk); rxd = 0; clks(300); rxd = 1; clks(12*BD);
    chk("R10 saturate", abd_count, 255);
    abd_en = 0; rx_ie = 1;
    @(negedge clk); rx_read = 1; @(negedge clk); rx_read = 0;
  endtask

  initial begin
    clks(3); rst_n = 1; clks(2);
    t_reset; t_tx; t_rx; t_sleep_tx; t_sleep_rx; t_retain; t_idle; t_wake; t_abd;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule